// File: doc/BRIEF.md
# Boot-Parameter and Console Register Block

This block is a slave on a simple request/response register bus. Boot software uses it to read the platform's parameters: CPU count, CPU clock in MHz, memory size, kernel start, end and entry addresses, and interrupt clock frequency. The same block provides several other functions:

- a one-character console port in each direction;
- a set of disk-transfer parameter registers, with a command register that starts an external block read;
- an array of per-CPU start values, which secondary processors poll.

Each request is decoded by byte offset and by access size. The block answers with success or bad-address status after a fixed, parameterised latency. An illegal request leaves all state unchanged.

The control path is a three-state machine:

- **IDLE**: `req_ready` is high. On `req_valid` the request is captured and the transition *accept* moves to WAIT.
- **WAIT**: a latency counter, loaded with `LAT_CYCLES-1`, counts down. The transition *expire*, taken when the counter reaches zero, moves to DONE.
- **DONE**: lasts one cycle. The response is presented, any write or strobe takes effect, and the transition *retire* returns to IDLE.

Offsets, as byte addresses:

| Offset | Access | Field |
|---|---|---|
| 0x00 | 32-bit | last valid offset |
| 0x04 | 32-bit | version |
| 0x08 | 32-bit | CPU count |
| 0x0C | 32-bit | interrupt frequency |
| 0x10 | 64-bit | console input |
| 0x18 | 64-bit | CPU MHz |
| 0x20 | 64-bit | memory size |
| 0x28 | 64-bit | kernel start |
| 0x30 | 64-bit | kernel end |
| 0x38 | 64-bit | kernel entry |
| 0x40 | 64-bit | disk unit |
| 0x48 | 64-bit | disk count |
| 0x50 | 64-bit | disk physical address |
| 0x58 | 64-bit | disk block |
| 0x60 | 64-bit | disk command |
| 0x68 | 64-bit | console output |
| 0x70 to 0x70+8·NSLOT−1 | 64-bit | per-CPU slots |

Top module: `bootcfg_regs`

## Requirements
- R1: A read with `req_size`=4 succeeds only at 0x00 (returns 0x70+8·NSLOT−1, which is 0x26F by default), 0x04 (`VERSION`), 0x08 (CPU count) and 0x0C (interrupt frequency). Any other 4-byte read returns `resp_ok`=0.
- R2: A read with `req_size`=8 succeeds at every 8-aligned offset from 0x10 to 0x68 and anywhere in the slot range. The disk command and console output offsets read as 0. Every other 8-byte read fails.
- R3: A request whose size is neither 4 nor 8 fails, has no effect on any register, and raises no strobe.
- R4: A write succeeds only with size 8 and only at 0x40, 0x48, 0x50, 0x58, 0x60, 0x68 or a slot. Any other write fails and changes nothing. A successful write to 0x40–0x58 updates the field that is read back at the same offset.
- R5: Writing 0x13 to 0x60 pulses `dsk_go` for the DONE cycle, with the current physical address, block and count on `dsk_paddr`, `dsk_block` and `dsk_count`. Any other value at 0x60 fails with no pulse.
- R6: A successful write to 0x68 pulses `con_out_strobe` for one cycle, with `con_out_char` equal to bits 7:0 of the written data.
- R7: An 8-byte read of 0x10 behaves as follows. If `con_in_valid` is high, it returns `con_in_char` zero-extended and pulses `con_in_pop` for one cycle. Otherwise it returns all ones and does not pulse.
- R8: The slot index is (offset−0x70)>>3, so a byte offset that is not 8-aligned still selects the slot containing it. A slot write of zero fails and leaves the slot unchanged.
- R9: After reset, the disk unit reads 1. The disk count, address and block, every slot, and every platform field read 0 until loaded.
- R10: The first `plat_load` pulse after reset captures the platform inputs. Later pulses are ignored.
- R11: A request accepted on clock edge k gets `resp_valid` high for exactly one cycle, after edge k+`LAT_CYCLES`. `req_ready` is low from edge k until after that response.
- R12: `resp_rdata` is 0 on failed requests and on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Access size in bytes |
| req_offset | input | OFFW | Byte offset inside the block |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response cycle |
| resp_ok | output | 1 | 1 = success, 0 = bad address |
| resp_rdata | output | 64 | Read data |
| plat_load | input | 1 | Platform parameter capture strobe |
| plat_ncpu | input | 32 | CPU count |
| plat_irq_hz | input | 32 | Interrupt clock frequency |
| plat_clk_mhz | input | 64 | CPU clock in MHz |
| plat_mem_bytes | input | 64 | Memory size |
| plat_kern_start | input | 64 | Kernel start address |
| plat_kern_end | input | 64 | Kernel end address |
| plat_kern_entry | input | 64 | Kernel entry point |
| con_in_valid | input | 1 | Console input character pending |
| con_in_char | input | 8 | Pending console input character |
| con_in_pop | output | 1 | Consume pending input character |
| con_out_strobe | output | 1 | Console output character valid |
| con_out_char | output | 8 | Console output character |
| dsk_go | output | 1 | Disk read request pulse |
| dsk_paddr | output | 64 | Disk transfer physical address |
| dsk_block | output | 64 | Disk transfer block number |
| dsk_count | output | 64 | Disk transfer count |

## Verification
Every result of a request lands in the DONE cycle, exactly `LAT_CYCLES` edges after the accepting edge. This covers the response, the status, the read data and the three strobes. Register updates become visible to the next request. The bench therefore drives each request at a falling edge and checks one nanosecond after the accepting edge that no response has appeared yet. It then waits exactly `LAT_CYCLES` rising edges and samples every output one nanosecond later. A response that arrives early or late shows up as a missing or misplaced beat. Reads are swept over every byte offset at both legal sizes, and expected values come from an arithmetic model of the offset map.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

    // byte offset where the 64-bit fields start, and where the slot array starts
    localparam int WIDE_BASE = 16;
    localparam int SLOT_BASE = 112;

    localparam logic [63:0] DISK_READ_CMD = 64'h13;

    typedef enum logic [4:0] {
        FLD_NONE, FLD_LASTOFF, FLD_VERSION, FLD_NCPU, FLD_IRQF,
        FLD_CIN, FLD_CPUCLK, FLD_MEMSZ, FLD_KSTART, FLD_KEND, FLD_ENTRY,
        FLD_DUNIT, FLD_DCOUNT, FLD_DPADDR, FLD_DBLOCK, FLD_DOP, FLD_COUT,
        FLD_SLOT
    } field_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_WAIT, ST_DONE
    } phase_e;

endpackage

// File: rtl/bootcfg_decode.sv
module bootcfg_decode
    import bootcfg_pkg::*;
#(
    parameter int NSLOT = 64,
    parameter int OFFW  = 10,
    parameter int IDXW  = 6
) (
    input  logic [OFFW-1:0] off,
    input  logic [3:0]      size,
    input  logic            write,
    input  logic [63:0]     wdata,
    output field_e          fld,
    output logic            legal,
    output logic [IDXW-1:0] idx
);

    localparam logic [OFFW-1:0] WIDE_LO = OFFW'(WIDE_BASE);
    localparam logic [OFFW-1:0] SLOT_LO = OFFW'(SLOT_BASE);
    localparam logic [OFFW-1:0] SLOT_HI = OFFW'(SLOT_BASE + NSLOT * 8);

    logic [OFFW-1:0] wide_rel;
    logic [OFFW-1:0] slot_rel;

    always_comb begin
        wide_rel = off - WIDE_LO;
        slot_rel = off - SLOT_LO;
        fld      = FLD_NONE;
        idx      = '0;

        if (size == 4'd4) begin
            if      (off == OFFW'(0))  fld = FLD_LASTOFF;
            else if (off == OFFW'(4))  fld = FLD_VERSION;
            else if (off == OFFW'(8))  fld = FLD_NCPU;
            else if (off == OFFW'(12)) fld = FLD_IRQF;
        end else if (size == 4'd8) begin
            if (off >= SLOT_LO && off < SLOT_HI) begin
                fld = FLD_SLOT;
                idx = slot_rel[IDXW+2:3];
            end else if (off >= WIDE_LO && off < SLOT_LO && off[2:0] == 3'd0) begin
                case (wide_rel[6:3])
                    4'd0:    fld = FLD_CIN;
                    4'd1:    fld = FLD_CPUCLK;
                    4'd2:    fld = FLD_MEMSZ;
                    4'd3:    fld = FLD_KSTART;
                    4'd4:    fld = FLD_KEND;
                    4'd5:    fld = FLD_ENTRY;
                    4'd6:    fld = FLD_DUNIT;
                    4'd7:    fld = FLD_DCOUNT;
                    4'd8:    fld = FLD_DPADDR;
                    4'd9:    fld = FLD_DBLOCK;
                    4'd10:   fld = FLD_DOP;
                    4'd11:   fld = FLD_COUT;
                    default: fld = FLD_NONE;
                endcase
            end
        end

        if (!write) begin
            legal = (fld != FLD_NONE);
        end else begin
            case (fld)
                FLD_DUNIT, FLD_DCOUNT, FLD_DPADDR, FLD_DBLOCK, FLD_COUT: legal = 1'b1;
                FLD_DOP:  legal = (wdata == DISK_READ_CMD);
                FLD_SLOT: legal = (wdata != 64'd0);
                default:  legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/bootcfg_ctrl.sv
module bootcfg_ctrl
    import bootcfg_pkg::*;
#(
    parameter int LAT_CYCLES = 16,
    parameter int OFFW       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [3:0]      req_size,
    input  logic [OFFW-1:0] req_offset,
    input  logic [63:0]     req_wdata,
    output logic            req_ready,
    output logic            fire,
    output logic            cap_write,
    output logic [3:0]      cap_size,
    output logic [OFFW-1:0] cap_off,
    output logic [63:0]     cap_wdata
);

    localparam int CNTW = $clog2(LAT_CYCLES + 1);

    phase_e          st_q, st_d;
    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid)         st_d = ST_WAIT;   // accept
            ST_WAIT: if (cnt_q == '0)       st_d = ST_DONE;   // expire
            ST_DONE:                        st_d = ST_IDLE;   // retire
            default:                        st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cap_write <= 1'b0;
            cap_size  <= '0;
            cap_off   <= '0;
            cap_wdata <= '0;
        end else if (st_q == ST_IDLE && req_valid) begin
            cnt_q     <= CNTW'(LAT_CYCLES - 1);
            cap_write <= req_write;
            cap_size  <= req_size;
            cap_off   <= req_offset;
            cap_wdata <= req_wdata;
        end else if (st_q == ST_WAIT && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        req_ready = (st_q == ST_IDLE);
        fire      = (st_q == ST_DONE);
    end

    a_r11_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    a_r11_accept_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!fire && !req_ready));

endmodule

// File: rtl/bootcfg_store.sv
module bootcfg_store
    import bootcfg_pkg::*;
#(
    parameter int          NSLOT   = 64,
    parameter int          IDXW    = 6,
    parameter logic [31:0] VERSION = 32'h0000_0002
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            write,
    input  field_e          fld,
    input  logic            legal,
    input  logic [IDXW-1:0] idx,
    input  logic [63:0]     wdata,
    input  logic            plat_load,
    input  logic [31:0]     plat_ncpu,
    input  logic [31:0]     plat_irq_hz,
    input  logic [63:0]     plat_clk_mhz,
    input  logic [63:0]     plat_mem_bytes,
    input  logic [63:0]     plat_kern_start,
    input  logic [63:0]     plat_kern_end,
    input  logic [63:0]     plat_kern_entry,
    input  logic            con_in_valid,
    input  logic [7:0]      con_in_char,
    output logic [63:0]     rdata,
    output logic            con_in_pop,
    output logic            con_out_strobe,
    output logic [7:0]      con_out_char,
    output logic            dsk_go,
    output logic [63:0]     dsk_paddr,
    output logic [63:0]     dsk_block,
    output logic [63:0]     dsk_count
);

    localparam logic [31:0] LAST_OFF = 32'(SLOT_BASE + NSLOT * 8 - 1);

    logic        loaded_q;
    logic [31:0] ncpu_q, irq_q;
    logic [63:0] mhz_q, mem_q, kstart_q, kend_q, entry_q;
    logic [63:0] dunit_q;
    logic [63:0] slot_q [NSLOT];
    logic        wr_ok;

    assign wr_ok = fire && legal && write;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            ncpu_q   <= '0;
            irq_q    <= '0;
            mhz_q    <= '0;
            mem_q    <= '0;
            kstart_q <= '0;
            kend_q   <= '0;
            entry_q  <= '0;
        end else if (plat_load && !loaded_q) begin
            loaded_q <= 1'b1;
            ncpu_q   <= plat_ncpu;
            irq_q    <= plat_irq_hz;
            mhz_q    <= plat_clk_mhz;
            mem_q    <= plat_mem_bytes;
            kstart_q <= plat_kern_start;
            kend_q   <= plat_kern_end;
            entry_q  <= plat_kern_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dunit_q   <= 64'd1;
            dsk_count <= '0;
            dsk_paddr <= '0;
            dsk_block <= '0;
        end else if (wr_ok) begin
            case (fld)
                FLD_DUNIT:  dunit_q   <= wdata;
                FLD_DCOUNT: dsk_count <= wdata;
                FLD_DPADDR: dsk_paddr <= wdata;
                FLD_DBLOCK: dsk_block <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
        end else if (wr_ok && fld == FLD_SLOT) begin
            slot_q[idx] <= wdata;
        end
    end

    always_comb begin
        case (fld)
            FLD_LASTOFF: rdata = {32'd0, LAST_OFF};
            FLD_VERSION: rdata = {32'd0, VERSION};
            FLD_NCPU:    rdata = {32'd0, ncpu_q};
            FLD_IRQF:    rdata = {32'd0, irq_q};
            FLD_CIN:     rdata = con_in_valid ? {56'd0, con_in_char} : '1;
            FLD_CPUCLK:  rdata = mhz_q;
            FLD_MEMSZ:   rdata = mem_q;
            FLD_KSTART:  rdata = kstart_q;
            FLD_KEND:    rdata = kend_q;
            FLD_ENTRY:   rdata = entry_q;
            FLD_DUNIT:   rdata = dunit_q;
            FLD_DCOUNT:  rdata = dsk_count;
            FLD_DPADDR:  rdata = dsk_paddr;
            FLD_DBLOCK:  rdata = dsk_block;
            FLD_SLOT:    rdata = slot_q[idx];
            default:     rdata = '0;
        endcase
    end

    always_comb begin
        dsk_go         = wr_ok && fld == FLD_DOP;
        con_out_strobe = wr_ok && fld == FLD_COUT;
        con_out_char   = wdata[7:0];
        con_in_pop     = fire && legal && !write && fld == FLD_CIN && con_in_valid;
    end

    a_r5_go_legal: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_go |-> (fire && legal && wdata == DISK_READ_CMD));
    a_r6_out_legal: assert property (@(posedge clk) disable iff (!rst_n)
        con_out_strobe |-> (fire && legal && write));
    a_r7_pop_pending: assert property (@(posedge clk) disable iff (!rst_n)
        con_in_pop |-> con_in_valid);
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dsk_go, con_out_strobe, con_in_pop}));
    a_r10_plat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && $past(loaded_q)) |-> ($stable(ncpu_q) && $stable(mem_q)));

endmodule

// File: rtl/bootcfg_regs.sv
module bootcfg_regs
    import bootcfg_pkg::*;
#(
    parameter int          LAT_CYCLES = 16,
    parameter int          NSLOT      = 64,
    parameter logic [31:0] VERSION    = 32'h0000_0002,
    localparam int         OFFW       = $clog2(SLOT_BASE + NSLOT * 8 + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [3:0]      req_size,
    input  logic [OFFW-1:0] req_offset,
    input  logic [63:0]     req_wdata,
    output logic            resp_valid,
    output logic            resp_ok,
    output logic [63:0]     resp_rdata,
    input  logic            plat_load,
    input  logic [31:0]     plat_ncpu,
    input  logic [31:0]     plat_irq_hz,
    input  logic [63:0]     plat_clk_mhz,
    input  logic [63:0]     plat_mem_bytes,
    input  logic [63:0]     plat_kern_start,
    input  logic [63:0]     plat_kern_end,
    input  logic [63:0]     plat_kern_entry,
    input  logic            con_in_valid,
    input  logic [7:0]      con_in_char,
    output logic            con_in_pop,
    output logic            con_out_strobe,
    output logic [7:0]      con_out_char,
    output logic            dsk_go,
    output logic [63:0]     dsk_paddr,
    output logic [63:0]     dsk_block,
    output logic [63:0]     dsk_count
);

    localparam int IDXW = $clog2(NSLOT);

    logic            fire, cap_write, legal;
    logic [3:0]      cap_size;
    logic [OFFW-1:0] cap_off;
    logic [63:0]     cap_wdata, rd;
    logic [IDXW-1:0] idx;
    field_e          fld;

    bootcfg_ctrl #(.LAT_CYCLES(LAT_CYCLES), .OFFW(OFFW)) u_ctrl (
        .clk, .rst_n, .req_valid, .req_write, .req_size, .req_offset, .req_wdata,
        .req_ready, .fire, .cap_write, .cap_size, .cap_off, .cap_wdata
    );

    bootcfg_decode #(.NSLOT(NSLOT), .OFFW(OFFW), .IDXW(IDXW)) u_dec (
        .off(cap_off), .size(cap_size), .write(cap_write), .wdata(cap_wdata),
        .fld, .legal, .idx
    );

    bootcfg_store #(.NSLOT(NSLOT), .IDXW(IDXW), .VERSION(VERSION)) u_store (
        .clk, .rst_n, .fire, .write(cap_write), .fld, .legal, .idx, .wdata(cap_wdata),
        .plat_load, .plat_ncpu, .plat_irq_hz, .plat_clk_mhz, .plat_mem_bytes,
        .plat_kern_start, .plat_kern_end, .plat_kern_entry,
        .con_in_valid, .con_in_char, .rdata(rd), .con_in_pop, .con_out_strobe,
        .con_out_char, .dsk_go, .dsk_paddr, .dsk_block, .dsk_count
    );

    always_comb begin
        resp_valid = fire;
        resp_ok    = fire && legal;
        resp_rdata = (fire && legal && !cap_write) ? rd : '0;
    end

    a_r12_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (!resp_ok || cap_write)) |-> (resp_rdata == 64'd0));
    a_r11_ok_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> resp_valid);

endmodule

// File: tb/test_bootcfg_regs.sv
`timescale 1ns/1ps
module test_bootcfg_regs;

    localparam int LAT = 3;
    localparam logic [31:0] VER = 32'h0000_0002;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, req_valid, req_ready, req_write;
    logic [3:0]  req_size;
    logic [9:0]  req_offset;
    logic [63:0] req_wdata;
    logic        resp_valid, resp_ok;
    logic [63:0] resp_rdata;
    logic        plat_load;
    logic [31:0] plat_ncpu, plat_irq_hz;
    logic [63:0] plat_clk_mhz, plat_mem_bytes, plat_kern_start, plat_kern_end, plat_kern_entry;
    logic        con_in_valid, con_in_pop, con_out_strobe, dsk_go;
    logic [7:0]  con_in_char, con_out_char;
    logic [63:0] dsk_paddr, dsk_block, dsk_count;

    bootcfg_regs #(.LAT_CYCLES(LAT), .NSLOT(64), .VERSION(VER)) i_bootcfg_regs (.*);

    int n_cmp = 0, n_bad = 0;

    // model of architecturally visible state
    logic [63:0] m_ncpu, m_irq, m_mhz, m_mem, m_ks, m_ke, m_en;
    logic [63:0] m_unit, m_cnt, m_addr, m_blk;
    logic [63:0] m_slot [64];

    // sampled response
    logic        g_valid, g_ok, g_go, g_out, g_pop;
    logic [63:0] g_rd, g_paddr, g_blk, g_cnt;
    logic [7:0]  g_char;

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [3:0] sz, input logic [9:0] off, input logic [63:0] wd);
        @(negedge clk);
        chk(req_ready === 1'b1, "R11 ready in idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = w; req_size = sz; req_offset = off; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(resp_valid === 1'b0 && req_ready === 1'b0, "R11 no early response",
            64'({resp_valid, req_ready}), 64'd0);
        repeat (LAT) @(posedge clk);
        #1;
        g_valid = resp_valid; g_ok = resp_ok; g_rd = resp_rdata;
        g_go = dsk_go; g_out = con_out_strobe; g_char = con_out_char; g_pop = con_in_pop;
        g_paddr = dsk_paddr; g_blk = dsk_block; g_cnt = dsk_count;
        chk(g_valid === 1'b1, "R11 response on time", 64'(g_valid), 64'd1);
        @(posedge clk); #1;
        chk(resp_valid === 1'b0, "R11 single beat", 64'(resp_valid), 64'd0);
    endtask

    function automatic void predict(input logic w, input logic [3:0] sz, input int off,
                                    input logic [63:0] wd, output logic ok, output logic [63:0] rd);
        ok = 1'b0; rd = '0;
        if (sz == 4 && !w) begin
            case (off)
                0:  begin ok = 1; rd = 64'd623; end
                4:  begin ok = 1; rd = 64'(VER); end
                8:  begin ok = 1; rd = m_ncpu; end
                12: begin ok = 1; rd = m_irq; end
                default: ;
            endcase
        end else if (sz == 8) begin
            if (off >= 112 && off < 624) begin
                if (w) ok = (wd != 0);
                else begin ok = 1; rd = m_slot[(off - 112) / 8]; end
            end else if (off >= 16 && off % 8 == 0) begin
                case ((off - 16) / 8)
                    0:  if (!w) begin ok = 1; rd = con_in_valid ? 64'(con_in_char) : '1; end
                    1:  if (!w) begin ok = 1; rd = m_mhz; end
                    2:  if (!w) begin ok = 1; rd = m_mem; end
                    3:  if (!w) begin ok = 1; rd = m_ks; end
                    4:  if (!w) begin ok = 1; rd = m_ke; end
                    5:  if (!w) begin ok = 1; rd = m_en; end
                    6:  begin ok = 1; rd = w ? '0 : m_unit; end
                    7:  begin ok = 1; rd = w ? '0 : m_cnt; end
                    8:  begin ok = 1; rd = w ? '0 : m_addr; end
                    9:  begin ok = 1; rd = w ? '0 : m_blk; end
                    10: ok = w ? (wd == 64'h13) : 1'b1;
                    11: ok = 1'b1;
                    default: ;
                endcase
            end
        end
    endfunction

    task automatic run(input logic w, input logic [3:0] sz, input int off, input logic [63:0] wd, input string tag);
        logic e_ok;
        logic [63:0] e_rd;
        logic e_go, e_out, e_pop;
        predict(w, sz, off, wd, e_ok, e_rd);
        e_go  = e_ok && w && off == 96;
        e_out = e_ok && w && off == 104;
        e_pop = e_ok && !w && sz == 8 && off == 16 && con_in_valid;
        access(w, sz, 10'(off), wd);
        chk(g_ok === e_ok && g_rd === e_rd, {tag, " status/data"}, g_rd, e_rd);
        chk(g_go === e_go && g_out === e_out && g_pop === e_pop, {tag, " strobes (R3 R5 R6 R7)"},
            64'({g_go, g_out, g_pop}), 64'({e_go, e_out, e_pop}));
        if (e_go)
            chk(g_paddr === m_addr && g_blk === m_blk && g_cnt === m_cnt, "R5 disk parameters",
                g_paddr ^ g_blk ^ g_cnt, m_addr ^ m_blk ^ m_cnt);
        if (e_out)
            chk(g_char === wd[7:0], "R6 output char", 64'(g_char), 64'(wd[7:0]));
        if (e_ok && w) begin
            if (off >= 112)    m_slot[(off - 112) / 8] = wd;
            else if (off == 64) m_unit = wd;
            else if (off == 72) m_cnt  = wd;
            else if (off == 80) m_addr = wd;
            else if (off == 88) m_blk  = wd;
        end
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_offset = 0; req_wdata = 0;
        plat_load = 0; plat_ncpu = 32'd4; plat_irq_hz = 32'd1024; plat_clk_mhz = 64'd1500;
        plat_mem_bytes = 64'h1_0000_0000; plat_kern_start = 64'hFFFF_FC00_0031_0000;
        plat_kern_end = 64'hFFFF_FC00_0090_0000; plat_kern_entry = 64'hFFFF_FC00_0031_0040;
        con_in_valid = 0; con_in_char = 8'h5C;
        m_ncpu = 0; m_irq = 0; m_mhz = 0; m_mem = 0; m_ks = 0; m_ke = 0; m_en = 0;
        m_unit = 64'd1; m_cnt = 0; m_addr = 0; m_blk = 0;
        for (int i = 0; i < 64; i++) m_slot[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R9: reset state
        @(negedge clk);
        chk(req_ready === 1 && resp_valid === 0 && dsk_go === 0 && con_out_strobe === 0 && con_in_pop === 0,
            "R9 reset outputs", 64'({req_ready, resp_valid, dsk_go, con_out_strobe, con_in_pop}), 64'h10);
        chk(dsk_paddr === 0 && dsk_block === 0 && dsk_count === 0, "R9 disk regs cleared",
            dsk_paddr | dsk_block | dsk_count, 64'd0);
        run(0, 4'd4, 8, 0, "R9 CPU count before load");
        run(0, 4'd8, 64, 0, "R9 disk unit reset");

        // R10: first load captures, second is ignored
        @(negedge clk); plat_load = 1; @(negedge clk); plat_load = 0;
        m_ncpu = 64'd4; m_irq = 64'd1024; m_mhz = 64'd1500; m_mem = plat_mem_bytes;
        m_ks = plat_kern_start; m_ke = plat_kern_end; m_en = plat_kern_entry;
        plat_ncpu = 32'd9; plat_mem_bytes = 64'd77; plat_kern_entry = 64'd5;
        @(negedge clk); plat_load = 1; @(negedge clk); plat_load = 0;
        run(0, 4'd4, 8, 0, "R10 CPU count kept");
        run(0, 4'd8, 32, 0, "R10 memory size kept");
        run(0, 4'd8, 56, 0, "R10 entry kept");

        // R1: every byte offset at 4-byte reads
        for (int o = 0; o < 624; o++) run(0, 4'd4, o, 0, "R1 32-bit read sweep");
        // R2 R7 R8 R9: every byte offset at 8-byte reads, no console char pending
        for (int o = 0; o < 624; o++) run(0, 4'd8, o, 0, "R2 64-bit read sweep");

        // R3: odd sizes, reads and writes
        for (int s = 0; s < 16; s++)
            if (s != 4 && s != 8) begin
                run(0, 4'(s), 64, 0, "R3 bad size read");
                run(1, 4'(s), 64, 64'hDEAD, "R3 bad size write");
            end
        run(0, 4'd8, 64, 0, "R3 disk unit untouched");

        // R4: writes at every aligned fixed offset, then read back
        for (int o = 0; o < 112; o += 8) run(1, 4'd8, o, 64'hA5A5_0000_0000_0100 + 64'(o), "R4 write sweep");
        run(1, 4'd4, 72, 64'h1234, "R4 narrow write rejected");
        for (int o = 0; o < 112; o += 8) run(0, 4'd8, o, 0, "R4 read back");
        run(0, 4'd4, 8, 0, "R4 CPU count not writable");

        // R5: disk command
        run(1, 4'd8, 80, 64'h0000_0000_8000_0000, "R5 set paddr");
        run(1, 4'd8, 88, 64'd42, "R5 set block");
        run(1, 4'd8, 72, 64'd8, "R5 set count");
        run(1, 4'd8, 96, 64'h13, "R5 launch read");
        run(1, 4'd8, 96, 64'h12, "R5 bad command");
        run(0, 4'd8, 96, 0, "R5 command reads zero");

        // R6: console output keeps low byte only
        run(1, 4'd8, 104, 64'hFFFF_0000_1234_56A5, "R6 output char");
        run(0, 4'd8, 104, 0, "R12 output reads zero");

        // R7: console input pending and absent
        con_in_valid = 1;
        run(0, 4'd8, 16, 0, "R7 input char pending");
        con_in_valid = 0;
        run(0, 4'd8, 16, 0, "R7 input char absent");

        // R8: every slot, written, then read through a misaligned offset
        for (int i = 0; i < 64; i++)
            run(1, 4'd8, 112 + 8 * i, 64'h0101_0101_0101_0101 * 64'(i + 1), "R8 slot write");
        for (int i = 0; i < 64; i++) run(0, 4'd8, 112 + 8 * i + (i % 8), 0, "R8 slot read");
        run(1, 4'd8, 112 + 8 * 5, 64'd0, "R8 zero write rejected");
        run(0, 4'd8, 112 + 8 * 5, 0, "R8 slot unchanged");
        run(1, 4'd8, 624, 64'd7, "R8 beyond last slot");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule